// File: doc/BRIEF.md
# Auto-Incrementing Buffer Memory Data Port

This block gives a host a window onto a byte-wide local SRAM buffer of up to 64 KB through a single fixed data location. A 16-bit address pointer, loaded by the host, selects the SRAM byte. Every host access to the data location becomes one or two SRAM byte cycles, and the pointer advances by one after each byte. So a stream of host accesses walks through the buffer with no further address writes.

Host accesses are 8 or 16 bits wide. When the wide-port configuration input is set, a 32-bit host transfer arrives as one 16-bit access to the low register pair and then one 16-bit access to the high register pair. Both pairs feed the same byte stream. When that input is clear, the high pair is inert. SRAM cycles start only while an arbitration grant input is high. The host is held off through a ready signal until all byte cycles of its access are done. After every read, the port fetches the next byte ahead of time, so the following read can take its first byte without waiting for the SRAM.

Top module: `sram_byte_port`

## Requirements
- R1: A `hostSel`=0 write loads `hostWrData` into the pointer. A `hostSel`=0 read returns the pointer on `hostRdData`. Neither starts an SRAM cycle.
- R2: A 16-bit data write (`hostWide`=1) writes `hostWrData[7:0]` at the pointer and then `hostWrData[15:8]` at pointer+1. The pointer ends 2 higher.
- R3: A 16-bit data read returns the byte at the pointer on bits [7:0] and the byte at pointer+1 on bits [15:8]. The pointer ends 2 higher.
- R4: An 8-bit data access (`hostWide`=0) moves one byte on bits [7:0] and advances the pointer by 1. For a read, bits [15:8] are 0.
- R5: The pointer wraps from FFFFh to 0000h. It changes only by a load or by +1.
- R6: `hostReady` drops in the cycle after a data access is accepted and stays low until its last byte cycle is done. `sramRe`/`sramWe` are never high while `memGrant` is low, and they are never both high.
- R7: `hostSel`=1 is the low register pair. With `cfgWide32`=1, `hostSel`=2 (the high register pair) continues the same byte stream. With `cfgWide32`=0, `hostSel`=2, and `hostSel`=3 in every mode, start no SRAM cycle, leave the pointer unchanged and read as 0.
- R8: After each data read, the byte at the new pointer is fetched ahead of time, and the next read uses it without a new SRAM cycle. N bytes read one access at a time, with idle gaps between accesses, cost N+1 SRAM reads. A data write or a pointer load discards the fetched byte.
- R9: After reset the pointer is 0, `hostReady` is 1, `hostRdData` is 0 and no SRAM strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostStart | input | 1 | Starts an access; taken only while hostReady is 1 |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostSel | input | 2 | 0 pointer, 1 low data pair, 2 high data pair, 3 unused |
| hostWide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Host read data, valid when hostReady returns |
| hostReady | output | 1 | 1 = port can take an access; low = host stalled |
| cfgWide32 | input | 1 | Enables the high data pair (32-bit mode) |
| memGrant | input | 1 | Arbitration grant; SRAM cycles start only while 1 |
| sramAddr | output | 16 | SRAM byte address |
| sramWrData | output | 8 | SRAM write byte |
| sramRdData | input | 8 | SRAM read byte, valid the cycle after sramRe |
| sramRe | output | 1 | SRAM read strobe |
| sramWe | output | 1 | SRAM write strobe |

## Verification
The hardest case to reach is a stale prefetched byte. It needs a read that leaves a fetched byte behind, followed by a data write or a pointer load, and only then another read. It is also easy to miss, because when the host issues accesses back to back the pending fetch is usually abandoned. The stimulus therefore inserts idle gaps after reads, so that the fetch can finish. It then writes or reloads the pointer and reads again, and it counts SRAM read strobes to confirm that one byte was fetched ahead. Random operations under a randomly dropped grant then mix the same sequences with stalls.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_RWAIT,
    ST_PREF,
    ST_PWAIT
  } portState_t;

  localparam logic [1:0] SEL_PTR = 2'd0;
  localparam logic [1:0] SEL_DLO = 2'd1;
  localparam logic [1:0] SEL_DHI = 2'd2;

  // Strobes from the control sequencer to the datapath.
  typedef struct packed {
    logic latchReq;  // capture write data, clear read assembly
    logic ptrLoad;   // load pointer from host data
    logic ptrToRd;   // pointer value to read data
    logic zeroRd;    // inert access: read data = 0
    logic ptrInc;    // advance pointer by one
    logic capSram;   // byte from SRAM into read lane
    logic capBuf;    // byte from prefetch buffer into read lane
    logic pfFill;    // load prefetch buffer from SRAM
    logic pfClear;   // discard prefetch buffer
    logic issueRd;   // SRAM read cycle
    logic issueWr;   // SRAM write cycle
    logic lane;      // byte lane of the current transfer
  } portStrobe_t;

endpackage

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_port_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostStart,
  input  logic        hostWrite,
  input  logic [1:0]  hostSel,
  input  logic        hostWide,
  input  logic        cfgWide32,
  input  logic        memGrant,
  input  logic        pfValid,
  output logic        hostReady,
  output portStrobe_t strobe
);

  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  portState_t state, nextState;
  logic [LANE_W-1:0] byteIdx;
  logic reqWrite, reqWide;
  logic accept, dataSel, lastByte, byteAdv;

  assign dataSel  = (hostSel == SEL_DLO) || ((hostSel == SEL_DHI) && cfgWide32);
  assign lastByte = !reqWide || (byteIdx == LAST_LANE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      byteIdx  <= '0;
      reqWrite <= 1'b0;
      reqWide  <= 1'b0;
    end else begin
      state <= nextState;
      if (accept && dataSel) begin
        reqWrite <= hostWrite;
        reqWide  <= hostWide;
        byteIdx  <= '0;
      end else if (byteAdv) begin
        byteIdx <= byteIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    hostReady = 1'b0;
    accept    = 1'b0;
    byteAdv   = 1'b0;
    strobe.lane = byteIdx[0];
    unique case (state)
      ST_IDLE, ST_PREF: begin
        hostReady = 1'b1;
        if (hostStart) begin
          accept = 1'b1;
          nextState = ST_IDLE;
          if (hostSel == SEL_PTR) begin
            if (hostWrite) begin
              strobe.ptrLoad = 1'b1;
              strobe.pfClear = 1'b1;
            end else begin
              strobe.ptrToRd = 1'b1;
            end
          end else if (dataSel) begin
            strobe.latchReq = 1'b1;
            if (hostWrite) strobe.pfClear = 1'b1;
            nextState = ST_XFER;
          end else if (!hostWrite) begin
            strobe.zeroRd = 1'b1;
          end
        end else if (state == ST_PREF && memGrant) begin
          strobe.issueRd = 1'b1;
          nextState = ST_PWAIT;
        end
      end
      ST_XFER: begin
        if (reqWrite) begin
          if (memGrant) begin
            strobe.issueWr = 1'b1;
            strobe.ptrInc  = 1'b1;
            if (lastByte) nextState = ST_IDLE;
            else byteAdv = 1'b1;
          end
        end else if (pfValid) begin
          strobe.capBuf  = 1'b1;
          strobe.pfClear = 1'b1;
          strobe.ptrInc  = 1'b1;
          if (lastByte) nextState = ST_PREF;
          else byteAdv = 1'b1;
        end else if (memGrant) begin
          strobe.issueRd = 1'b1;
          nextState = ST_RWAIT;
        end
      end
      ST_RWAIT: begin
        strobe.capSram = 1'b1;
        strobe.ptrInc  = 1'b1;
        if (lastByte) nextState = ST_PREF;
        else begin
          byteAdv   = 1'b1;
          nextState = ST_XFER;
        end
      end
      ST_PWAIT: begin
        strobe.pfFill = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  AST_GRANT_GATES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issueRd || strobe.issueWr) |-> memGrant); // R6

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.issueRd, strobe.issueWr})); // R6

  AST_WRITE_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueWr |-> !hostReady); // R6

  AST_ACCEPT_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (hostStart && hostReady && dataSel) |=> !hostReady); // R6

  AST_INERT_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    (hostStart && hostReady && hostSel != SEL_PTR && !dataSel) |=> hostReady); // R7

endmodule

// File: rtl/sram_port_dp.sv
module sram_port_dp
  import sram_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  localparam int HW    = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strobe,
  input  logic [HW-1:0]     hostWrData,
  output logic [HW-1:0]     hostRdData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [BYTE_W-1:0] sramWrData,
  input  logic [BYTE_W-1:0] sramRdData,
  output logic              sramRe,
  output logic              sramWe,
  output logic              pfValid
);

  logic [ADDR_W-1:0] ptr;
  logic [HW-1:0]     wrHold;
  logic [HW-1:0]     ptrWide;
  logic [BYTE_W-1:0] pfData;

  assign ptrWide = HW'(ptr);

  always_ff @(posedge clk) begin
    if (!rstN) ptr <= '0;
    else if (strobe.ptrLoad) ptr <= ADDR_W'(hostWrData);
    else if (strobe.ptrInc) ptr <= ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) wrHold <= '0;
    else if (strobe.latchReq) wrHold <= hostWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pfValid <= 1'b0;
      pfData  <= '0;
    end else if (strobe.pfFill) begin
      pfValid <= 1'b1;
      pfData  <= sramRdData;
    end else if (strobe.pfClear) begin
      pfValid <= 1'b0;
    end
  end

  // One assembly register per host byte lane.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit = (int'(strobe.lane) == g);
    always_ff @(posedge clk) begin
      if (!rstN) hostRdData[g*BYTE_W +: BYTE_W] <= '0;
      else if (strobe.zeroRd || strobe.latchReq) hostRdData[g*BYTE_W +: BYTE_W] <= '0;
      else if (strobe.ptrToRd) hostRdData[g*BYTE_W +: BYTE_W] <= ptrWide[g*BYTE_W +: BYTE_W];
      else if (strobe.capSram && hit) hostRdData[g*BYTE_W +: BYTE_W] <= sramRdData;
      else if (strobe.capBuf && hit) hostRdData[g*BYTE_W +: BYTE_W] <= pfData;
    end
  end

  assign sramAddr   = ptr;
  assign sramWrData = wrHold[int'(strobe.lane)*BYTE_W +: BYTE_W];
  assign sramRe     = strobe.issueRd;
  assign sramWe     = strobe.issueWr;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ptr != $past(ptr)) |-> ((ptr == $past(ptr) + 1'b1) || $past(strobe.ptrLoad))); // R5

  AST_PF_FROM_SRAM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pfValid) |-> $past(sramRe, 2)); // R8

  AST_WRITE_DROPS_PF: assert property (@(posedge clk) disable iff (!rstN)
    sramWe |=> !pfValid); // R8

endmodule

// File: rtl/sram_byte_port.sv
module sram_byte_port
  import sram_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  localparam int LANES = 2,
  localparam int HW    = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostStart,
  input  logic              hostWrite,
  input  logic [1:0]        hostSel,
  input  logic              hostWide,
  input  logic [HW-1:0]     hostWrData,
  output logic [HW-1:0]     hostRdData,
  output logic              hostReady,
  input  logic              cfgWide32,
  input  logic              memGrant,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [BYTE_W-1:0] sramWrData,
  input  logic [BYTE_W-1:0] sramRdData,
  output logic              sramRe,
  output logic              sramWe
);

  portStrobe_t strobe;
  logic pfValid;

  sram_port_ctrl #(.LANES(LANES)) ctrl_i (
    .clk(clk), .rstN(rstN), .hostStart(hostStart), .hostWrite(hostWrite),
    .hostSel(hostSel), .hostWide(hostWide), .cfgWide32(cfgWide32),
    .memGrant(memGrant), .pfValid(pfValid), .hostReady(hostReady),
    .strobe(strobe)
  );

  sram_port_dp #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LANES(LANES)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .sramAddr(sramAddr), .sramWrData(sramWrData),
    .sramRdData(sramRdData), .sramRe(sramRe), .sramWe(sramWe),
    .pfValid(pfValid)
  );

endmodule

// File: tb/sram_byte_port_tb_top.sv
module sram_byte_port_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostStart = 1'b0, hostWrite = 1'b0, hostWide = 1'b0;
  logic [1:0] hostSel = 2'd0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic hostReady;
  logic cfgWide32 = 1'b0;
  logic memGrant = 1'b1;
  logic [15:0] sramAddr;
  logic [7:0] sramWrData;
  logic [7:0] sramRdData = '0;
  logic sramRe, sramWe;

  always #2.5 clk = ~clk;

  sram_byte_port dut_i (
    .clk(clk), .rstN(rstN), .hostStart(hostStart), .hostWrite(hostWrite),
    .hostSel(hostSel), .hostWide(hostWide), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .hostReady(hostReady), .cfgWide32(cfgWide32),
    .memGrant(memGrant), .sramAddr(sramAddr), .sramWrData(sramWrData),
    .sramRdData(sramRdData), .sramRe(sramRe), .sramWe(sramWe)
  );

  // SRAM model (12 address bits kept) and reference copy.
  logic [7:0] sramMem [4096];
  logic [7:0] refMem  [4096];
  logic [15:0] refPtr = '0;
  int rdCount = 0, wrCount = 0, grantViol = 0;
  int grantMode = 0; // 0 high, 1 random, 2 low
  int compared = 0, mismatched = 0;

  always @(posedge clk) begin
    if (sramWe) sramMem[sramAddr[11:0]] <= sramWrData;
    if (sramRe) sramRdData <= sramMem[sramAddr[11:0]];
    if (rstN) begin
      if (sramRe) rdCount <= rdCount + 1;
      if (sramWe) wrCount <= wrCount + 1;
      if ((sramRe || sramWe) && !memGrant) grantViol <= grantViol + 1;
    end
  end

  always @(negedge clk) begin
    case (grantMode)
      0: memGrant = 1'b1;
      1: memGrant = ($urandom % 3) != 0;
      default: memGrant = 1'b0;
    endcase
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic isData(input logic [1:0] sel);
    return (sel == 2'd1) || (sel == 2'd2 && cfgWide32);
  endfunction

  // Reference: returns expected read data and updates model state.
  function automatic logic [15:0] refAccess(input bit wr, input logic [1:0] sel,
                                            input bit wide, input logic [15:0] wd);
    logic [15:0] exp = '0;
    if (sel == 2'd0) begin
      if (wr) refPtr = wd; else exp = refPtr;
    end else if (isData(sel)) begin
      for (int i = 0; i < (wide ? 2 : 1); i++) begin
        if (wr) refMem[refPtr[11:0]] = wd[i*8 +: 8];
        else exp[i*8 +: 8] = refMem[refPtr[11:0]];
        refPtr = refPtr + 16'd1;
      end
    end
    return exp;
  endfunction

  task automatic issue(input bit wr, input logic [1:0] sel, input bit wide,
                       input logic [15:0] wd, output logic [15:0] rd);
    while (!hostReady) @(negedge clk);
    hostStart = 1'b1; hostWrite = wr; hostSel = sel; hostWide = wide; hostWrData = wd;
    @(negedge clk);
    hostStart = 1'b0;
    while (!hostReady) @(negedge clk);
    rd = hostRdData;
  endtask

  task automatic op(input bit wr, input logic [1:0] sel, input bit wide, input logic [15:0] wd);
    logic [15:0] rd, exp;
    string tag;
    exp = refAccess(wr, sel, wide, wd);
    issue(wr, sel, wide, wd, rd);
    if (!wr) begin
      if (sel == 2'd0) tag = "R1 pointer read";
      else if (!isData(sel)) tag = "R7 inert read";
      else if (wide) tag = "R3 wide read";
      else tag = "R4 byte read";
      chk(tag, rd, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ptrCheck(input string tag, input logic [15:0] exp);
    logic [15:0] rd;
    issue(1'b0, 2'd0, 1'b1, 16'h0, rd);
    chk(tag, rd, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int rc0, wc0;
    logic [15:0] rd;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) begin sramMem[i] = 8'h00; refMem[i] = 8'h00; end
    repeat (4) @(negedge clk);
    // R9 reset state
    chk("R9 ready", {31'd0, hostReady}, 32'd1);
    chk("R9 rdData", {16'd0, hostRdData}, 32'd0);
    chk("R9 strobes", {30'd0, sramRe, sramWe}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    ptrCheck("R9 pointer after reset", 16'h0000);

    // R1 pointer load and readback
    op(1'b1, 2'd0, 1'b1, 16'h1234);
    ptrCheck("R1 pointer load", 16'h1234);

    // R2 wide write byte order
    op(1'b1, 2'd1, 1'b1, 16'hABCD);
    chk("R2 low byte at ptr", {24'd0, sramMem[12'h234]}, 32'h0000_00CD);
    chk("R2 high byte at ptr+1", {24'd0, sramMem[12'h235]}, 32'h0000_00AB);
    ptrCheck("R2 pointer +2", 16'h1236);

    // R3 wide read
    op(1'b1, 2'd0, 1'b1, 16'h1234);
    op(1'b0, 2'd1, 1'b1, 16'h0);
    ptrCheck("R3 pointer +2", 16'h1236);

    // R4 byte access
    op(1'b1, 2'd0, 1'b1, 16'h1300);
    op(1'b1, 2'd1, 1'b0, 16'hEE5A);
    chk("R4 byte written", {24'd0, sramMem[12'h300]}, 32'h0000_005A);
    chk("R4 next byte untouched", {24'd0, sramMem[12'h301]}, 32'h0000_0000);
    ptrCheck("R4 pointer +1", 16'h1301);
    op(1'b1, 2'd0, 1'b1, 16'h1300);
    op(1'b0, 2'd1, 1'b0, 16'h0);

    // R5 wrap
    op(1'b1, 2'd0, 1'b1, 16'hFFFF);
    op(1'b1, 2'd1, 1'b1, 16'h7788);
    chk("R5 byte at FFFF", {24'd0, sramMem[12'hFFF]}, 32'h0000_0088);
    chk("R5 byte at 0000", {24'd0, sramMem[12'h000]}, 32'h0000_0077);
    ptrCheck("R5 pointer wrapped", 16'h0001);

    // R6 stall while grant low
    op(1'b1, 2'd0, 1'b1, 16'h0100);
    grantMode = 2;
    @(negedge clk);
    wc0 = wrCount;
    void'(refAccess(1'b1, 2'd1, 1'b1, 16'h3C4B));
    hostStart = 1'b1; hostWrite = 1'b1; hostSel = 2'd1; hostWide = 1'b1; hostWrData = 16'h3C4B;
    @(negedge clk);
    hostStart = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk("R6 stalled while no grant", {31'd0, hostReady}, 32'd0);
      @(negedge clk);
    end
    chk("R6 no write without grant", wrCount, wc0);
    grantMode = 0;
    while (!hostReady) @(negedge clk);
    chk("R6 writes after grant", wrCount, wc0 + 2);
    chk("R6 data landed", {16'd0, sramMem[12'h101], sramMem[12'h100]}, 32'h0000_3C4B);

    // R7 inert high pair when 32-bit mode off
    cfgWide32 = 1'b0;
    op(1'b1, 2'd0, 1'b1, 16'h0200);
    rc0 = rdCount; wc0 = wrCount;
    idle(4);
    rc0 = rdCount;
    op(1'b1, 2'd2, 1'b1, 16'h9999);
    op(1'b0, 2'd2, 1'b1, 16'h0);
    op(1'b0, 2'd3, 1'b1, 16'h0);
    chk("R7 no SRAM write", wrCount, wc0);
    chk("R7 no SRAM read", rdCount, rc0);
    ptrCheck("R7 pointer unchanged", 16'h0200);
    // R7 32-bit mode: doubleword over two register pairs
    cfgWide32 = 1'b1;
    op(1'b1, 2'd1, 1'b1, 16'h2211);
    op(1'b1, 2'd2, 1'b1, 16'h4433);
    chk("R7 dword bytes", {sramMem[12'h203], sramMem[12'h202], sramMem[12'h201], sramMem[12'h200]},
        32'h4433_2211);
    op(1'b1, 2'd0, 1'b1, 16'h0200);
    op(1'b0, 2'd1, 1'b1, 16'h0);
    op(1'b0, 2'd2, 1'b1, 16'h0);

    // R8 prefetch: N bytes cost N+1 SRAM reads with gaps
    op(1'b1, 2'd0, 1'b1, 16'h0300);
    op(1'b1, 2'd1, 1'b1, 16'hB2A1);
    op(1'b1, 2'd1, 1'b1, 16'hD4C3);
    op(1'b1, 2'd1, 1'b1, 16'hF6E5);
    op(1'b1, 2'd0, 1'b1, 16'h0300);
    idle(2);
    rc0 = rdCount;
    op(1'b0, 2'd1, 1'b1, 16'h0); idle(4);
    op(1'b0, 2'd1, 1'b1, 16'h0); idle(4);
    op(1'b0, 2'd1, 1'b0, 16'h0); idle(4);
    chk("R8 reads for 5 bytes", rdCount - rc0, 6);
    // R8 write discards prefetched byte
    op(1'b1, 2'd0, 1'b1, 16'h0300);
    op(1'b0, 2'd1, 1'b0, 16'h0); idle(4);
    op(1'b1, 2'd1, 1'b0, 16'h0077);
    op(1'b0, 2'd1, 1'b0, 16'h0);
    chk("R8 read after write", {16'd0, hostRdData}, 32'h0000_00C3);
    // R8 pointer load discards prefetched byte
    op(1'b0, 2'd1, 1'b0, 16'h0); idle(4);
    op(1'b1, 2'd0, 1'b1, 16'h0305);
    op(1'b0, 2'd1, 1'b0, 16'h0);
    chk("R8 read after reload", {16'd0, hostRdData}, 32'h0000_00F6);

    // Random mix with random grant
    grantMode = 1;
    for (int n = 0; n < 600; n++) begin
      int kind = $urandom % 10;
      if (($urandom % 16) == 0) cfgWide32 = $urandom % 2;
      if (kind == 0) op(1'b1, 2'd0, 1'b1, 16'($urandom));
      else if (kind == 1) op(1'b0, 2'd0, 1'b1, 16'h0);
      else if (kind < 5) op(1'b1, 2'($urandom % 4), 1'($urandom % 2), 16'($urandom));
      else op(1'b0, 2'($urandom % 4), 1'($urandom % 2), 16'h0);
      if (($urandom % 3) == 0) idle($urandom % 4);
    end
    grantMode = 0;
    ptrCheck("R5 pointer after random run", refPtr);
    chk("R6 strobes only under grant", grantViol, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule